// File: doc/BRIEF.md
# Output Compare Channel Bank

This block drives a bank of output-compare channels from a shared 16-bit free-running timer count. The count value and a one-cycle tick strobe come in from outside, and each channel compares its own stored value against the count on every tick. When a channel's value matches, the block records the event in that channel's sticky flag. It also updates the channel's output pin with the action chosen for that channel: no action, toggle, drive low or drive high.

A disconnect mask decides, per channel, whether a match may reach the pin. When a channel is disconnected, its pin keeps its value, but the flag still records every match. Software can therefore keep timing events while it holds the pin steady.

Software uses a simple synchronous register port to reach the compare values, the action selects, the flags and the mask. It can also read the pin state back.

Top module: `oc_bank`

## Requirements
- R1: After reset, all compare values, all action selects, every flag, every disconnect bit and every output pin are 0.
- R2: A match happens on a clock where `cnt_tick` is 1 and `cnt_val` equals a channel's compare value. That channel's flag is 1 one clock later. An equal count without a tick causes no match.
- R3: Writing address NCH+1 clears each flag whose write-data bit (bit i for channel i) is 1. Bits written as 0 leave their flags unchanged. If a clear and a match hit the same channel on the same clock, the flag ends up set. A flag never rises without a match.
- R4: The action select is 2 bits per channel, at bits 2i+1:2i of address NCH. The codes are: 00 leaves the pin, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The action is applied on the clock after the match.
- R5: When a channel's disconnect bit is 1, a match leaves that channel's pin unchanged, but the channel's flag is still set. Clearing the bit again restores the pin action on the next match.
- R6: The disconnect mask is at address NCH+2, bit i for channel i. It can be written and read back at any time, and every bit resets to 0 so that all channels are connected.
- R7: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented. Address NCH+1 returns the flags and address NCH+3 returns the pin state.
- R8: The compare value of channel i is at address i, and it can be written and read back.
- R9: A pin keeps its value on every clock where its channel has no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count advanced on this clock; compares are evaluated only then |
| cnt_val | input | CW (16) | Current timer count |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | DW (16) | Register write data |
| bus_rdata | output | DW (16) | Registered read data for the previous address |
| oc_pins | output | NCH (8) | Output-compare pin levels |
| cmp_flags | output | NCH (8) | Sticky compare event flags |

## Verification
A match presented on the tick sampled at one rising edge shows up on `cmp_flags` and `oc_pins` after that same edge. The bench therefore drives the tick on a falling edge and compares both outputs against its model on the next falling edge. A register read is due one edge after the address, so the read task queues its expected value before that edge, and the monitor pops the item and compares it 2 ns after the edge. Register writes take effect at the edge that samples them, so any dependent tick or read is issued no earlier than the following falling edge.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  // control register offsets relative to the channel count
  localparam int OFS_ACT  = 0;
  localparam int OFS_FLAG = 1;
  localparam int OFS_MASK = 2;
  localparam int OFS_PINS = 3;
  localparam int N_CTRL   = 4;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              tick,
  input  logic [CW-1:0]     cnt,
  input  logic [NCH*CW-1:0] cmp_flat,
  output logic [NCH-1:0]    match
);
  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign match[i] = tick && (cnt == cmp_flat[i*CW +: CW]);
  end
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
  import oc_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   match,
  input  logic [NCH-1:0]   mask,
  input  logic [2*NCH-1:0] act_flat,
  output logic [NCH-1:0]   pins
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    oc_act_e act;
    assign act = oc_act_e'(act_flat[2*i +: 2]);
    always_ff @(posedge clk) begin
      if (rst) begin
        pins[i] <= 1'b0;
      end else if (match[i] && !mask[i]) begin
        case (act)
          ACT_TOGGLE: pins[i] <= ~pins[i];
          ACT_CLEAR:  pins[i] <= 1'b0;
          ACT_SET:    pins[i] <= 1'b1;
          default:    pins[i] <= pins[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH-1:0]    match,
  input  logic [NCH-1:0]    pins,
  output logic [NCH*CW-1:0] cmp_flat,
  output logic [2*NCH-1:0]  act_flat,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    flags,
  output logic [DW-1:0]     rdata
);
  localparam logic [AW-1:0] A_ACT  = AW'(NCH + OFS_ACT);
  localparam logic [AW-1:0] A_FLAG = AW'(NCH + OFS_FLAG);
  localparam logic [AW-1:0] A_MASK = AW'(NCH + OFS_MASK);
  localparam logic [AW-1:0] A_PINS = AW'(NCH + OFS_PINS);

  logic [CW-1:0]  cmp_q [NCH];
  logic [NCH-1:0] clr;
  logic [DW-1:0]  rd_next;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)
        cmp_q[i] <= '0;
      else if (we && addr == AW'(i))
        cmp_q[i] <= wdata[CW-1:0];
    end
    assign cmp_flat[i*CW +: CW] = cmp_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_flat <= '0;
      mask     <= '0;
    end else if (we) begin
      if (addr == A_ACT)  act_flat <= wdata[2*NCH-1:0];
      if (addr == A_MASK) mask     <= wdata[NCH-1:0];
    end
  end

  assign clr = (we && addr == A_FLAG) ? wdata[NCH-1:0] : '0;

  // a match on the same clock outranks a clear
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | match;
  end

  always_comb begin
    rd_next = '0;
    if (int'(addr) < NCH) rd_next = DW'(cmp_q[addr[$clog2(NCH)-1:0]]);
    else if (addr == A_ACT)  rd_next = DW'(act_flat);
    else if (addr == A_FLAG) rd_next = DW'(flags);
    else if (addr == A_MASK) rd_next = DW'(mask);
    else if (addr == A_PINS) rd_next = DW'(pins);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/oc_bank.sv
module oc_bank
  import oc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  localparam int AW = $clog2(NCH + N_CTRL),
  localparam int DW = (CW > 2*NCH) ? CW : 2*NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cnt_val,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] oc_pins,
  output logic [NCH-1:0] cmp_flags
);
  logic [NCH*CW-1:0] cmp_flat;
  logic [2*NCH-1:0]  act_flat;
  logic [NCH-1:0]    dis_mask;
  logic [NCH-1:0]    match;

  oc_match #(.NCH(NCH), .CW(CW)) u_match (
    .tick(cnt_tick), .cnt(cnt_val), .cmp_flat(cmp_flat), .match(match)
  );

  oc_pin_ctrl #(.NCH(NCH)) u_pin (
    .clk(clk), .rst(rst), .match(match), .mask(dis_mask),
    .act_flat(act_flat), .pins(oc_pins)
  );

  oc_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .match(match), .pins(oc_pins), .cmp_flat(cmp_flat), .act_flat(act_flat),
    .mask(dis_mask), .flags(cmp_flags), .rdata(bus_rdata)
  );
endmodule

// File: rtl/oc_bank_chk.sv
module oc_bank_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] match,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] pins
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (flags == '0 && pins == '0)); // R1

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (match != '0) |=> ((flags & $past(match)) == $past(match))); // R2

  AST_FLAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |=> ((flags & ~$past(flags)) == '0)); // R3

  AST_DISC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ((match & mask) != '0) |=> (((pins ^ $past(pins)) & $past(match & mask)) == '0)); // R5

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |=> $stable(pins)); // R9
endmodule

bind oc_bank oc_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .match(match), .mask(dis_mask),
  .flags(cmp_flags), .pins(oc_pins)
);

// File: tb/sim_oc_bank.sv
module sim_oc_bank;
  localparam int NCH = 8;
  localparam int A_ACT = NCH, A_FLAG = NCH + 1, A_MASK = NCH + 2, A_PINS = NCH + 3;

  logic clk = 0, rst = 1, cnt_tick = 0, bus_we = 0;
  logic [15:0] cnt_val = 0, bus_wdata = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_rdata;
  logic [7:0]  oc_pins, cmp_flags;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int checks = 0, fails = 0;
  logic [15:0] m_cmp [NCH];
  logic [1:0]  m_act [NCH];
  logic [7:0]  m_pins = 0, m_flags = 0, m_mask = 0;

  always #5 clk = ~clk;

  oc_bank u0 (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected read per edge
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 4'(a);
    sb_q.push_back('{exp, tag});
    @(posedge clk);
    #3;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
    if (a < NCH) m_cmp[a] = d;
    else if (a == A_ACT) for (int i = 0; i < NCH; i++) m_act[i] = d[2*i +: 2];
    else if (a == A_MASK) m_mask = d[7:0];
    else if (a == A_FLAG) m_flags = m_flags & ~d[7:0];
    @(negedge clk);
    bus_we = 0;
  endtask

  function automatic void model_tick(input logic [15:0] v);
    for (int i = 0; i < NCH; i++)
      if (m_cmp[i] == v) begin
        m_flags[i] = 1'b1;
        if (!m_mask[i])
          case (m_act[i])
            2'b01: m_pins[i] = ~m_pins[i];
            2'b10: m_pins[i] = 1'b0;
            2'b11: m_pins[i] = 1'b1;
            default: ;
          endcase
      end
  endfunction

  task automatic tick(input logic [15:0] v, input logic en, input string tag);
    @(negedge clk);
    cnt_val = v; cnt_tick = en;
    if (en) model_tick(v);
    @(negedge clk);
    cnt_tick = 0;
    check({tag, " pins"}, {8'h0, oc_pins}, {8'h0, m_pins});
    check({tag, " flags"}, {8'h0, cmp_flags}, {8'h0, m_flags});
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]  acts [NCH] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b11, 2'b01, 2'b11};
    logic [15:0] aw;
    for (int i = 0; i < NCH; i++) begin m_cmp[i] = 0; m_act[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    check("R1 pins", {8'h0, oc_pins}, 16'h0);
    check("R1 flags", {8'h0, cmp_flags}, 16'h0);
    rd(A_MASK, 16'h0, "R1 R6 mask reset");
    rd(A_ACT, 16'h0, "R1 act reset");
    rd(3, 16'h0, "R1 cmp reset");
    // R8 compare values
    for (int i = 0; i < NCH; i++) wr(i, 16'(100 + 10*i));
    rd(3, 16'd130, "R8 cmp3");
    rd(7, 16'd170, "R8 cmp7");
    aw = 0;
    for (int i = 0; i < NCH; i++) aw[2*i +: 2] = acts[i];
    wr(A_ACT, aw);
    rd(A_ACT, aw, "R4 act readback");
    // R2 equal count without tick
    tick(16'd100, 1'b0, "R2 no tick");
    // R2 R4 matches
    tick(16'd100, 1'b1, "R2 R4 toggle ch0");
    tick(16'd120, 1'b1, "R4 set ch2");
    tick(16'd110, 1'b1, "R4 clear ch1");
    tick(16'd130, 1'b1, "R4 none ch3");
    tick(16'd150, 1'b1, "R4 set ch5");
    tick(16'd100, 1'b1, "R4 toggle ch0 back");
    tick(16'd101, 1'b1, "R2 no match value");
    // R9 hold
    repeat (4) @(negedge clk);
    check("R9 pins hold", {8'h0, oc_pins}, {8'h0, m_pins});
    rd(A_PINS, {8'h0, m_pins}, "R7 pins read");
    rd(A_FLAG, {8'h0, m_flags}, "R7 flags read");
    // R3 clear
    wr(A_FLAG, 16'h0001);
    check("R3 clear ch0", {8'h0, cmp_flags}, {8'h0, m_flags});
    wr(A_FLAG, 16'h0000);
    check("R3 zero write", {8'h0, cmp_flags}, {8'h0, m_flags});
    // R3 set wins over clear
    @(negedge clk);
    bus_we = 1; bus_addr = 4'(A_FLAG); bus_wdata = 16'h0004;
    cnt_tick = 1; cnt_val = 16'd120;
    model_tick(16'd120);
    @(negedge clk);
    bus_we = 0; cnt_tick = 0;
    check("R3 set wins", {8'h0, cmp_flags}, {8'h0, m_flags});
    // R5 R6 disconnect mid-run
    wr(A_FLAG, 16'h00FF);
    tick(16'd140, 1'b1, "R5 ch4 connected toggle");
    wr(A_MASK, 16'h0011);
    rd(A_MASK, 16'h0011, "R6 mask readback");
    wr(A_FLAG, 16'h0011);
    tick(16'd140, 1'b1, "R5 ch4 disconnected frozen");
    tick(16'd100, 1'b1, "R5 ch0 disconnected frozen");
    check("R5 flag still raised", {8'h0, cmp_flags & 8'h11}, 16'h0011);
    wr(A_MASK, 16'h0000);
    tick(16'd140, 1'b1, "R5 ch4 reconnected");
    tick(16'd160, 1'b1, "R4 toggle ch6");
    rd(A_PINS, {8'h0, m_pins}, "R7 pins final");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule